// File: doc/BRIEF.md
# Flag-Setting Add Unit

This block is the add execution unit of a small RISC pipeline. It forms the sum of a first register operand and a second operand in a single combinational pass. The second operand is either another register or a sign-extended 16-bit immediate, and the stored carry flag is added in for the two carrying operations. The result and a write-enable leave the unit in the cycle in which the request is valid, and the pipeline writes the result back on the same clock edge.

The unit keeps a three-bit status register: a carry flag, an overflow flag and an enable for overflow exceptions. Every valid add updates both flags from the full sum, carry-in included. When the enable bit is set, an add that overflows signals a range exception as a one-cycle pulse, while its result and flags still take effect. Software can load the status bits through a one-cycle write port. Instruction decode, the register file and exception vectoring live elsewhere.

Top module: `flag_add_unit`

## Requirements
- R1: `op_sel` selects the operation: bit 1 set uses the immediate in place of `src_b`, and bit 0 set adds the stored carry flag. `result` is the sum of the selected operands modulo 2^32 in the same cycle as `op_valid`, and `result_we` equals `op_valid` outside reset.
- R2: The operations with `op_sel[0]` clear ignore the stored carry flag, so 1 + 2 gives 3 even when carry is set.
- R3: The 16-bit immediate is sign-extended before the add (0x8000 becomes 0xFFFF8000, 0xFFFE becomes 0xFFFFFFFE).
- R4: On each clock edge with `op_valid` high, `flag_carry` takes the unsigned carry out of bit 31 of the full sum, carry-in included (0xFFFFFFFF + 0 + 1 gives 0 with carry set, in either operand order).
- R5: On the same edge, `flag_ovf` takes the two's-complement overflow of the full sum, carry-in included. For example, 0x40000000 + 0x3FFFFFFF + 1 sets overflow, and 0xC0000000 + 0xBFFFFFFF + 1 clears it.
- R6: `range_exc` is high in exactly the cycles where `op_valid` is high, the add overflows and the stored `exc_enable` is set. A carry without overflow never raises it.
- R7: When `range_exc` fires, `result_we` is still high with the sum on `result`, and the flags still update on that edge.
- R8: A status write with `st_wr_en` loads `st_wr_data` (bit 0 carry, bit 1 overflow, bit 2 exception enable). If `op_valid` is high in the same cycle, carry and overflow take the add's values and only the enable bit takes the written value.
- R9: While `rst_n` is low, `result_we` and `range_exc` are low, and the edge clears carry, overflow and the exception enable.
- R10: With neither `op_valid` nor `st_wr_en` high, the three status bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An add request is present this cycle |
| op_sel | input | 2 | Operation: bit 1 selects the immediate, bit 0 selects carry-in |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate operand, sign-extended |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 3 | Status write value: bit 2 enable, bit 1 overflow, bit 0 carry |
| result | output | 32 | Sum |
| result_we | output | 1 | Write-back enable for the sum |
| range_exc | output | 1 | Overflow exception pulse |
| flag_carry | output | 1 | Stored carry flag |
| flag_ovf | output | 1 | Stored overflow flag |
| exc_enable | output | 1 | Stored overflow-exception enable |

## Verification
The bench sweeps every operation across a set of edge operands: zero, one, all ones, the two sign boundaries and their neighbours, and immediates on both sides of the 16-bit sign bit. It runs each case with carry-in both clear and set and with the exception enable both on and off. These sweeps catch a unit that adds carry into the non-carrying operations, zero-extends the immediate, or derives overflow from the operands alone. They also catch a carry taken without the carry-in, which turns 0xFFFFFFFF + 0 + 1 into a carry-clear result. Directed cases cover the collision of a status write with an add, where a unit that lets the write win would leave stale flags. Other directed cases cover reset asserted during a valid add, which must not pulse `range_exc`, and idle cycles, in which the flags must hold.

// File: rtl/flag_add_pkg.sv
// Package: shared operation encoding and status layout for the add unit.
// Assumes: the operation select is two bits, one for immediate, one for carry.
package flag_add_pkg;

    localparam int OP_CARRY_BIT = 0;   // op_sel bit: add the stored carry
    localparam int OP_IMM_BIT   = 1;   // op_sel bit: use the immediate

    typedef enum logic [1:0] {
        OP_ADD_REG = 2'b00,
        OP_ADC_REG = 2'b01,
        OP_ADD_IMM = 2'b10,
        OP_ADC_IMM = 2'b11
    } add_op_e;

    localparam int ST_W = 3;

    // Status word: bit 2 exception enable, bit 1 overflow, bit 0 carry.
    typedef struct packed {
        logic en;
        logic ovf;
        logic carry;
    } status_t;

endpackage

// File: rtl/flag_add_opsel.sv
// Module: operand selection. Picks the second operand (register or
// sign-extended immediate) and the carry-in for the requested operation.
// Assumes: IMM_W <= W; purely combinational.
module flag_add_opsel
    import flag_add_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [1:0]     op,
    input  logic [W-1:0]   reg_b,
    input  logic [IMM_W-1:0] imm,
    input  logic           carry_flag,
    output logic [W-1:0]   opnd_b,
    output logic           carry_in
);

    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] imm_ext;

    // Widen the immediate by repeating its sign bit, when it is narrower.
    generate
        if (EXT_W > 0) begin : g_sext
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_same
            assign imm_ext = imm[W-1:0];
        end
    endgenerate

    // Choose the second operand and gate the stored carry by the operation.
    always_comb begin
        opnd_b   = op[OP_IMM_BIT] ? imm_ext : reg_b;
        carry_in = op[OP_CARRY_BIT] & carry_flag;
    end

endmodule

// File: rtl/flag_add_core.sv
// Module: adder with flag generation. Produces the sum of a, b and carry-in
// and the unsigned carry and signed overflow of that complete sum.
// Assumes: purely combinational; width set by W.
module flag_add_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);

    logic [W:0] wide;

    // One-bit-wider add so the carry-out falls out of the top bit.
    always_comb begin
        wide  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum   = wide[W-1:0];
        carry = wide[W];
        // Like-signed operands with an opposite-signed sum overflow.
        ovf   = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
    end

endmodule

// File: rtl/flag_add_status.sv
// Module: status register holding carry, overflow and exception enable.
// An add updates both flags; a software write loads all three bits, but
// loses carry and overflow to an add in the same cycle.
// Assumes: synchronous active-low reset.
module flag_add_status
    import flag_add_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic            carry_new,
    input  logic            ovf_new,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_data,
    output status_t         st
);

    status_t wr_val;

    // Reinterpret the write data in the status layout.
    always_comb wr_val = status_t'(wr_data);

    // Register the status bits with add-over-write priority for the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            if (wr_en) begin
                st.en <= wr_val.en;
            end
            if (upd) begin
                st.carry <= carry_new;
                st.ovf   <= ovf_new;
            end else if (wr_en) begin
                st.carry <= wr_val.carry;
                st.ovf   <= wr_val.ovf;
            end
        end
    end

    // R8: a lone write loads every bit.
    p_lone_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !upd) |=> (st == $past(wr_val)));

    // R8: a write beside an add still sets the enable bit.
    p_write_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st.en == $past(wr_val.en)));

    // R10: idle cycles keep the status.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !upd) |=> $stable(st));

endmodule

// File: rtl/flag_add_unit.sv
// Module: top of the flag-setting add unit. Combines operand selection,
// the flag adder and the status register; drives the write-back and the
// range-exception pulse in the cycle of the request.
// Assumes: synchronous active-low reset; outputs are combinational on inputs
// and on the stored status.
module flag_add_unit
    import flag_add_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_sel,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             st_wr_en,
    input  logic [ST_W-1:0]  st_wr_data,
    output logic [W-1:0]     result,
    output logic             result_we,
    output logic             range_exc,
    output logic             flag_carry,
    output logic             flag_ovf,
    output logic             exc_enable
);

    logic [W-1:0] opnd_b;
    logic         cin;
    logic         sum_carry;
    logic         sum_ovf;
    status_t      st;

    flag_add_opsel #(.W(W), .IMM_W(IMM_W)) u_opsel (
        .op         (op_sel),
        .reg_b      (src_b),
        .imm        (imm),
        .carry_flag (st.carry),
        .opnd_b     (opnd_b),
        .carry_in   (cin)
    );

    flag_add_core #(.W(W)) u_core (
        .a     (src_a),
        .b     (opnd_b),
        .cin   (cin),
        .sum   (result),
        .carry (sum_carry),
        .ovf   (sum_ovf)
    );

    flag_add_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (op_valid),
        .carry_new (sum_carry),
        .ovf_new   (sum_ovf),
        .wr_en     (st_wr_en),
        .wr_data   (st_wr_data),
        .st        (st)
    );

    // Qualify write-back and exception by the request and by reset.
    always_comb begin
        result_we  = op_valid & rst_n;
        range_exc  = op_valid & rst_n & sum_ovf & st.en;
        flag_carry = st.carry;
        flag_ovf   = st.ovf;
        exc_enable = st.en;
    end

    // R6: the pulse needs the stored enable.
    p_exc_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        range_exc |-> exc_enable);

    // R6: the pulse is followed by a stored overflow flag.
    p_exc_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        range_exc |=> flag_ovf);

    // R7: an exception never suppresses the write-back.
    p_exc_keeps_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        range_exc |-> result_we);

    // R9: reset clears the status on the next edge.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!flag_carry && !flag_ovf && !exc_enable));

    // R5: a stored overflow implies the add was like-signed in its operands.
    p_ovf_signs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (src_a[W-1] != opnd_b[W-1])) |=> !flag_ovf);

endmodule

// File: tb/flag_add_unit_test.sv
// Bench: sweeps all operations over edge operands with carry-in and enable
// both ways, plus directed reset, hold and write-collision cases.
module flag_add_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [1:0]  op_sel;
    logic [31:0] src_a, src_b;
    logic [15:0] imm;
    logic        st_wr_en;
    logic [2:0]  st_wr_data;
    logic [31:0] result;
    logic        result_we, range_exc, flag_carry, flag_ovf, exc_enable;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_add_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .imm(imm), .st_wr_en(st_wr_en),
        .st_wr_data(st_wr_data), .result(result), .result_we(result_we),
        .range_exc(range_exc), .flag_carry(flag_carry), .flag_ovf(flag_ovf),
        .exc_enable(exc_enable)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] reg_val(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;
            2: return 32'h0000_0002;  3: return 32'h3FFF_FFFF;
            4: return 32'h4000_0000;  5: return 32'h7FFF_FFFF;
            6: return 32'h8000_0000;  7: return 32'hBFFF_FFFF;
            8: return 32'hC000_0000;  9: return 32'hFFFF_FFFE;
            10: return 32'hFFFF_FFFF; 11: return 32'h7FFF_8000;
            12: return 32'h8000_8000; 13: return 32'h8000_7FFF;
            14: return 32'h7FFF_C000; default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [15:0] imm_val(input int i);
        case (i)
            0: return 16'h0000; 1: return 16'h0001;
            2: return 16'h0002; 3: return 16'h7FFF;
            4: return 16'h8000; 5: return 16'hFFFE;
            6: return 16'hFFFF; default: return 16'h4000;
        endcase
    endfunction

    // Preload carry and enable, run one add, check same-cycle and next-cycle outputs.
    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic cin, input logic en);
        logic [31:0] bb;
        logic        ci;
        logic [32:0] s;
        logic        c, v;
        string       rtag;
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_data = {en, 1'b0, cin}; op_valid = 1'b0;
        @(negedge clk);
        st_wr_en = 1'b0;
        chk("R8 preload carry", {31'd0, flag_carry}, {31'd0, cin});
        bb = op[1] ? {{16{im[15]}}, im} : b;
        ci = op[0] & cin;
        s  = {1'b0, a} + {1'b0, bb} + {32'd0, ci};
        c  = s[32];
        v  = (a[31] == bb[31]) && (s[31] != a[31]);
        if (!op[0] && cin) rtag = "R2 result";
        else if (op[1])    rtag = "R3 result";
        else               rtag = "R1 result";
        op_valid = 1'b1; op_sel = op; src_a = a; src_b = b; imm = im;
        #1;
        chk(rtag, result, s[31:0]);
        chk("R7 write-enable", {31'd0, result_we}, 32'd1);
        chk("R6 range exception", {31'd0, range_exc}, {31'd0, en & v});
        @(negedge clk);
        op_valid = 1'b0;
        chk("R4 carry flag", {31'd0, flag_carry}, {31'd0, c});
        chk("R5 overflow flag", {31'd0, flag_ovf}, {31'd0, v});
        chk("R8 enable kept", {31'd0, exc_enable}, {31'd0, en});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1 act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b1; op_sel = 2'b00;
        src_a = 32'h4000_0000; src_b = 32'h4000_0000; imm = '0;
        st_wr_en = 1'b1; st_wr_data = 3'b111;
        #1;
        // R9: outputs held low in reset even with an overflowing request.
        chk("R9 we in reset", {31'd0, result_we}, 32'd0);
        chk("R9 exc in reset", {31'd0, range_exc}, 32'd0);
        @(negedge clk); @(negedge clk);
        chk("R9 status cleared", {29'd0, exc_enable, flag_ovf, flag_carry}, 32'd0);
        op_valid = 1'b0; st_wr_en = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        // Document corner cases (R4 R5): operand order and carry-in effects.
        run_op(2'b01, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b1, 1'b0);
        run_op(2'b01, 32'h0, 32'hFFFF_FFFF, 16'h0, 1'b1, 1'b0);
        run_op(2'b01, 32'h4000_0000, 32'h3FFF_FFFF, 16'h0, 1'b1, 1'b1);
        run_op(2'b01, 32'hC000_0000, 32'hBFFF_FFFF, 16'h0, 1'b1, 1'b1);
        run_op(2'b11, 32'h7FFF_C000, 32'h0, 16'h3FFF, 1'b1, 1'b1);

        // Sweep register operations.
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int k = 0; k < 4; k++)
                    run_op({1'b0, k[0]}, reg_val(i), reg_val(j), 16'h0, k[1], (i ^ j) & 1);

        // Sweep immediate operations.
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 8; j++)
                for (int k = 0; k < 4; k++)
                    run_op({1'b1, k[0]}, reg_val(i), 32'hDEAD_BEEF, imm_val(j), k[1], (i + j) & 1);

        // R10: flags hold through idle cycles.
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_data = 3'b011;
        @(negedge clk);
        st_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 hold", {29'd0, exc_enable, flag_ovf, flag_carry}, 32'd3);

        // R8: write collides with an add; add wins carry/overflow, write sets enable.
        op_valid = 1'b1; op_sel = 2'b00; src_a = 32'd1; src_b = 32'd2;
        st_wr_en = 1'b1; st_wr_data = 3'b111;
        #1;
        chk("R2 carry ignored", result, 32'd3);
        @(negedge clk);
        op_valid = 1'b0; st_wr_en = 1'b0;
        chk("R8 collision", {29'd0, exc_enable, flag_ovf, flag_carry}, 32'd4);

        // R9: reset during an overflowing add with enable set.
        rst_n = 1'b0; op_valid = 1'b1; src_a = 32'hBFFF_FFFF; src_b = 32'hBFFF_FFFF;
        #1;
        chk("R9 exc masked", {31'd0, range_exc}, 32'd0);
        chk("R9 we masked", {31'd0, result_we}, 32'd0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 mid-run clear", {29'd0, exc_enable, flag_ovf, flag_carry}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule